// File: doc/BRIEF.md
# Stack Push/Pop Address Engine

This block performs stack push and pop operations against a byte-addressed memory through a simple single-beat request/acknowledge port. It owns a 32-bit stack pointer. For each operation, two attributes control the behaviour. The operand size sets the step: 2 bytes for a word and 4 bytes for a doubleword. The stack-address size sets whether the full 32-bit pointer is used, or only its low 16 bits.

A push lowers the pointer and then stores the value at the new pointer. A pop reads at the current pointer and then raises it. A separate load port sets the pointer when the engine is idle. A requester pulses `req_valid` with the attributes and push data. It then waits for `done`. In the `done` cycle, `sp` shows the updated pointer and `pop_data` holds the result of a pop.

Top module: `stk_engine`

## Requirements
- R1: A push computes the new pointer as the old pointer minus the step. It writes the value at that new pointer (`mem_we`=1, `mem_addr` = new pointer), and `sp` takes the new pointer.
- R2: A pop reads at the current pointer (`mem_we`=0, `mem_addr` = old pointer), and `sp` then takes the old pointer plus the step.
- R3: The step is 2 when `req_wide_op`=0 and 4 when `req_wide_op`=1. The byte-enable is 4'b0011 for a 2-byte step and 4'b1111 for a 4-byte step, and no other value is ever issued.
- R4: With `req_wide_sp`=1, all 32 pointer bits are used and updated. With `req_wide_sp`=0, `mem_addr` is the low 16 pointer bits zero-extended. In this mode the low 16 bits wrap modulo 65536 and bits 31:16 of `sp` are left unchanged.
- R5: Byte lane k of `mem_wdata`/`mem_rdata` (bits 8k+7:8k) is the byte at `mem_addr`+k, so the least significant byte sits at the lowest address.
- R6: A word pop returns `mem_rdata[15:0]` zero-extended to 32 bits, and a doubleword pop returns all 32 bits. `pop_data` keeps its value across pushes until the next pop.
- R7: `mem_req` stays high, with `mem_addr`, `mem_be`, `mem_we` and `mem_wdata` unchanged, until a cycle in which `mem_ack` is high.
- R8: `done` is high for exactly one cycle. That cycle follows the clock edge at which `mem_ack` was seen, and `sp` already holds the updated value in it.
- R9: While an operation is in progress (from acceptance through the `done` cycle), `req_valid` and `ptr_wr_en` are ignored.
- R10: Reset sets `sp` to 0 and clears `done` and `mem_req`. When idle, `ptr_wr_en` loads `ptr_wr_data` into `sp` on the next edge. A request in that same cycle is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Operation request strobe |
| req_pop | input | 1 | 1 = pop, 0 = push |
| req_wide_op | input | 1 | Operand size: 1 = 32-bit, 0 = 16-bit |
| req_wide_sp | input | 1 | Stack-address size: 1 = 32-bit pointer, 0 = 16-bit pointer |
| push_data | input | 32 | Value to push |
| ptr_wr_en | input | 1 | Pointer load strobe |
| ptr_wr_data | input | 32 | Pointer load value |
| pop_data | output | 32 | Last popped value |
| done | output | 1 | One-cycle completion pulse |
| sp | output | 32 | Current stack pointer |
| mem_req | output | 1 | Memory request, held until acknowledge |
| mem_we | output | 1 | 1 = write (push), 0 = read (pop) |
| mem_addr | output | 32 | Byte address of lane 0 |
| mem_be | output | 4 | Byte-lane enables |
| mem_wdata | output | 32 | Write data, little-endian lanes |
| mem_rdata | input | 32 | Read data, little-endian lanes |
| mem_ack | input | 1 | Memory acknowledge |

## Verification
A request sampled at edge E raises `mem_req` after E. The edge at which `mem_ack` is seen, call it A, updates `sp` and `pop_data`, and `done` is high for the cycle after A. The bench drives on falling edges and, after each request, steps falling edges until it sees `done`. It then reads `sp`, `pop_data` and the captured address and enables in that cycle, and checks that `done` is low one falling edge later. The memory model varies its acknowledge latency from zero to several cycles, so the pulse and sampling point are shown to track the acknowledge rather than a fixed count.

// File: rtl/stk_pkg.sv
package stk_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_BUS  = 2'd1,
    SEQ_DONE = 2'd2
  } seq_state_e;

  typedef struct packed {
    logic pop;      // 1 = pop, 0 = push
    logic wide_op;  // operand size: 1 = 4 bytes, 0 = 2 bytes
    logic wide_sp;  // pointer width: 1 = full, 0 = narrow
  } stk_op_t;

endpackage

// File: rtl/stk_ptr_math.sv
module stk_ptr_math
  import stk_pkg::*;
#(
  parameter int ADDR_W       = 32,
  parameter int NARROW_W     = 16,
  parameter int NARROW_BYTES = 2,
  parameter int WIDE_BYTES   = 4
) (
  input  stk_op_t           op,
  input  logic [ADDR_W-1:0] sp,
  output logic [ADDR_W-1:0] addr,
  output logic [ADDR_W-1:0] sp_next
);

  localparam int UPPER_W = ADDR_W - NARROW_W;
  localparam logic [ADDR_W-1:0] STEP_N = ADDR_W'(NARROW_BYTES);
  localparam logic [ADDR_W-1:0] STEP_W = ADDR_W'(WIDE_BYTES);

  logic [ADDR_W-1:0]   step;
  logic [ADDR_W-1:0]   full_adj;
  logic [NARROW_W-1:0] low_adj;
  logic [ADDR_W-1:0]   base;

  always_comb begin
    step     = op.wide_op ? STEP_W : STEP_N;
    full_adj = op.pop ? (sp + step) : (sp - step);
    low_adj  = op.pop ? (sp[NARROW_W-1:0] + step[NARROW_W-1:0])
                      : (sp[NARROW_W-1:0] - step[NARROW_W-1:0]);
    // Narrow mode keeps the upper part and wraps the low part.
    sp_next  = op.wide_sp ? full_adj : {sp[ADDR_W-1:NARROW_W], low_adj};
    // Push addresses the lowered pointer, pop the current one.
    base     = op.pop ? sp : sp_next;
    addr     = op.wide_sp ? base : {{UPPER_W{1'b0}}, base[NARROW_W-1:0]};
  end

endmodule

// File: rtl/stk_lane_pack.sv
module stk_lane_pack #(
  parameter int DATA_W   = 32,
  parameter int NARROW_W = 16
) (
  input  logic                wide_op,
  input  logic [DATA_W-1:0]   push_data,
  input  logic [DATA_W-1:0]   rdata,
  output logic [DATA_W/8-1:0] be,
  output logic [DATA_W-1:0]   wdata,
  output logic [DATA_W-1:0]   rd_ext
);

  localparam int BE_W         = DATA_W / 8;
  localparam int NARROW_LANES = NARROW_W / 8;

  for (genvar g = 0; g < BE_W; g++) begin : g_lane
    localparam bit IN_NARROW = (g < NARROW_LANES);
    assign be[g]             = wide_op | IN_NARROW;
    assign wdata[8*g +: 8]   = be[g] ? push_data[8*g +: 8] : 8'h00;
    assign rd_ext[8*g +: 8]  = be[g] ? rdata[8*g +: 8]     : 8'h00;
  end

endmodule

// File: rtl/stk_seq.sv
module stk_seq
  import stk_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  stk_op_t           req_op,
  input  logic [DATA_W-1:0] req_data,
  input  logic              ptr_wr_en,
  input  logic              mem_ack,
  output stk_op_t           op_q,
  output logic [DATA_W-1:0] data_q,
  output logic              ptr_load,
  output logic              commit,
  output logic              mem_req,
  output logic              mem_we,
  output logic              done
);

  seq_state_e state_q, state_d;
  logic       accept;

  always_comb begin
    ptr_load = (state_q == SEQ_IDLE) & ptr_wr_en;
    accept   = (state_q == SEQ_IDLE) & req_valid & ~ptr_wr_en;
    mem_req  = (state_q == SEQ_BUS);
    mem_we   = mem_req & ~op_q.pop;
    commit   = mem_req & mem_ack;
    done     = (state_q == SEQ_DONE);
  end

  always_comb begin
    state_d = state_q;
    case (state_q)
      SEQ_IDLE: if (accept) state_d = SEQ_BUS;
      SEQ_BUS:  if (mem_ack) state_d = SEQ_DONE;
      SEQ_DONE: state_d = SEQ_IDLE;
      default:  state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SEQ_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= '0;
      data_q <= '0;
    end else if (accept) begin
      op_q   <= req_op;
      data_q <= req_data;
    end
  end

endmodule

// File: rtl/stk_engine.sv
module stk_engine
  import stk_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int NARROW_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic                req_pop,
  input  logic                req_wide_op,
  input  logic                req_wide_sp,
  input  logic [DATA_W-1:0]   push_data,
  input  logic                ptr_wr_en,
  input  logic [ADDR_W-1:0]   ptr_wr_data,
  output logic [DATA_W-1:0]   pop_data,
  output logic                done,
  output logic [ADDR_W-1:0]   sp,
  output logic                mem_req,
  output logic                mem_we,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [DATA_W/8-1:0] mem_be,
  output logic [DATA_W-1:0]   mem_wdata,
  input  logic [DATA_W-1:0]   mem_rdata,
  input  logic                mem_ack
);

  localparam int NARROW_BYTES = NARROW_W / 8;
  localparam int WIDE_BYTES   = DATA_W / 8;

  stk_op_t           req_op;
  stk_op_t           op_q;
  logic [DATA_W-1:0] data_q;
  logic              ptr_load;
  logic              commit;
  logic [ADDR_W-1:0] sp_q, sp_d, sp_next;
  logic              sp_en;
  logic [DATA_W-1:0] pop_q, rd_ext;
  logic              pop_en;

  assign req_op = '{pop: req_pop, wide_op: req_wide_op, wide_sp: req_wide_sp};

  stk_seq #(.DATA_W(DATA_W)) i_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_op    (req_op),
    .req_data  (push_data),
    .ptr_wr_en (ptr_wr_en),
    .mem_ack   (mem_ack),
    .op_q      (op_q),
    .data_q    (data_q),
    .ptr_load  (ptr_load),
    .commit    (commit),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .done      (done)
  );

  stk_ptr_math #(
    .ADDR_W       (ADDR_W),
    .NARROW_W     (NARROW_W),
    .NARROW_BYTES (NARROW_BYTES),
    .WIDE_BYTES   (WIDE_BYTES)
  ) i_math (
    .op      (op_q),
    .sp      (sp_q),
    .addr    (mem_addr),
    .sp_next (sp_next)
  );

  stk_lane_pack #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) i_lanes (
    .wide_op   (op_q.wide_op),
    .push_data (data_q),
    .rdata     (mem_rdata),
    .be        (mem_be),
    .wdata     (mem_wdata),
    .rd_ext    (rd_ext)
  );

  always_comb begin
    sp_en  = ptr_load | commit;
    sp_d   = ptr_load ? ptr_wr_data : sp_next;
    pop_en = commit & op_q.pop;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sp_q <= '0;
    else if (sp_en) sp_q <= sp_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pop_q <= '0;
    else if (pop_en) pop_q <= rd_ext;
  end

  assign sp       = sp_q;
  assign pop_data = pop_q;

endmodule

// File: rtl/stk_engine_chk.sv
module stk_engine_chk #(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int NARROW_W = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                done,
  input logic [ADDR_W-1:0]   sp,
  input logic                mem_req,
  input logic                mem_ack,
  input logic                mem_we,
  input logic [ADDR_W-1:0]   mem_addr,
  input logic [DATA_W/8-1:0] mem_be,
  input logic [DATA_W-1:0]   mem_wdata
);

  localparam logic [DATA_W/8-1:0] BE_NARROW = (DATA_W/8)'((1 << (NARROW_W/8)) - 1);
  localparam logic [DATA_W/8-1:0] BE_WIDE   = '1;

  // R7: request and its fields hold until acknowledged
  a_r7_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_be)
                               && $stable(mem_we) && $stable(mem_wdata)));

  // R7: pointer does not move while a request waits
  a_r7_sp_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> $stable(sp));

  // R3: only the two legal byte-enable patterns
  a_r3_be_legal: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_be == BE_NARROW || mem_be == BE_WIDE));

  // R3: pointer moved by exactly one step in the done cycle
  a_r3_step_size: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (NARROW_W'(sp[NARROW_W-1:0] - $past(sp[NARROW_W-1:0])) == NARROW_W'(2)
           || NARROW_W'(sp[NARROW_W-1:0] - $past(sp[NARROW_W-1:0])) == NARROW_W'(4)
           || NARROW_W'($past(sp[NARROW_W-1:0]) - sp[NARROW_W-1:0]) == NARROW_W'(2)
           || NARROW_W'($past(sp[NARROW_W-1:0]) - sp[NARROW_W-1:0]) == NARROW_W'(4)));

  // R8: done follows an acknowledged request and lasts one cycle
  a_r8_done_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack) |=> (done && !mem_req));

  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9: no new request directly after completion
  a_r9_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !mem_req);

endmodule

bind stk_engine stk_engine_chk #(
  .ADDR_W   (ADDR_W),
  .DATA_W   (DATA_W),
  .NARROW_W (NARROW_W)
) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .done      (done),
  .sp        (sp),
  .mem_req   (mem_req),
  .mem_ack   (mem_ack),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .mem_be    (mem_be),
  .mem_wdata (mem_wdata)
);

// File: tb/test_stk_engine.sv
`timescale 1ns/1ps
module test_stk_engine;

  typedef struct packed {
    logic        pop;
    logic        wop;
    logic        wsp;
    logic [31:0] data;
    logic [31:0] exp_sp;
    logic [31:0] exp_addr;
    logic [3:0]  exp_be;
    logic [31:0] exp_pop;
  } vec_t;

  // Starting pointer 0x0001_0004, pop_data 0.
  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b1, 1'b1, 32'hA1B2C3D4, 32'h0001_0000, 32'h0001_0000, 4'hF, 32'h0000_0000},
    '{1'b0, 1'b0, 1'b1, 32'hFFFF5566, 32'h0000_FFFE, 32'h0000_FFFE, 4'h3, 32'h0000_0000},
    '{1'b1, 1'b0, 1'b1, 32'h0,        32'h0001_0000, 32'h0000_FFFE, 4'h3, 32'h0000_5566},
    '{1'b1, 1'b1, 1'b1, 32'h0,        32'h0001_0004, 32'h0001_0000, 4'hF, 32'hA1B2C3D4},
    '{1'b0, 1'b1, 1'b0, 32'h11223344, 32'h0001_0000, 32'h0000_0000, 4'hF, 32'hA1B2C3D4},
    '{1'b0, 1'b0, 1'b0, 32'h77779988, 32'h0001_FFFE, 32'h0000_FFFE, 4'h3, 32'hA1B2C3D4},
    '{1'b1, 1'b0, 1'b0, 32'h0,        32'h0001_0000, 32'h0000_FFFE, 4'h3, 32'h0000_9988},
    '{1'b1, 1'b1, 1'b0, 32'h0,        32'h0001_0004, 32'h0000_0000, 4'hF, 32'h1122_3344},
    '{1'b0, 1'b1, 1'b1, 32'hDEADBEEF, 32'h0001_0000, 32'h0001_0000, 4'hF, 32'h1122_3344},
    '{1'b1, 1'b0, 1'b1, 32'h0,        32'h0001_0002, 32'h0001_0000, 4'h3, 32'h0000_BEEF}
  };

  logic        clk;
  logic        rst_n;
  logic        req_valid, req_pop, req_wide_op, req_wide_sp;
  logic [31:0] push_data;
  logic        ptr_wr_en;
  logic [31:0] ptr_wr_data;
  logic [31:0] pop_data;
  logic        done;
  logic [31:0] sp;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr;
  logic [3:0]  mem_be;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata;
  logic        mem_ack;

  int checks = 0;
  int fails  = 0;
  int lat    = 0;
  int wait_cnt = 0;
  int req_count = 0;
  logic [31:0] last_addr;
  logic [3:0]  last_be;
  logic        last_we;
  logic [7:0]  mem [logic [31:0]];

  stk_engine i_stk_engine (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_pop     (req_pop),
    .req_wide_op (req_wide_op),
    .req_wide_sp (req_wide_sp),
    .push_data   (push_data),
    .ptr_wr_en   (ptr_wr_en),
    .ptr_wr_data (ptr_wr_data),
    .pop_data    (pop_data),
    .done        (done),
    .sp          (sp),
    .mem_req     (mem_req),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .mem_be      (mem_be),
    .mem_wdata   (mem_wdata),
    .mem_rdata   (mem_rdata),
    .mem_ack     (mem_ack)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // Byte-addressed memory model, little-endian lanes, variable latency.
  always @(negedge clk) begin
    if (!rst_n) begin
      mem_ack  = 1'b0;
      wait_cnt = 0;
    end else if (mem_ack) begin
      mem_ack = 1'b0;
    end else if (mem_req) begin
      if (wait_cnt >= lat) begin
        for (int k = 0; k < 4; k++) begin
          if (mem_we && mem_be[k]) mem[mem_addr + 32'(k)] = mem_wdata[8*k +: 8];
          mem_rdata[8*k +: 8] = mem.exists(mem_addr + 32'(k)) ? mem[mem_addr + 32'(k)] : 8'hA5;
        end
        last_addr = mem_addr;
        last_be   = mem_be;
        last_we   = mem_we;
        req_count++;
        wait_cnt  = 0;
        mem_ack   = 1'b1;
      end else begin
        wait_cnt++;
      end
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic wait_done();
    int n = 0;
    while (!done && n < 60) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic issue(input logic p, input logic wo, input logic ws, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_pop = p; req_wide_op = wo; req_wide_sp = ws; push_data = d;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual %h expected %h", 32'd0, 32'd1);
    finish_run();
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_pop = 1'b0; req_wide_op = 1'b0; req_wide_sp = 1'b0;
    push_data = '0; ptr_wr_en = 1'b0; ptr_wr_data = '0; mem_rdata = '0; mem_ack = 1'b0;
    repeat (3) @(negedge clk);
    // R10: reset state
    check(sp == 32'h0, "R10 reset sp", sp, 32'h0);
    check(!done && !mem_req, "R10 reset done/mem_req", {30'd0, done, mem_req}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R10: pointer load while idle
    ptr_wr_en = 1'b1; ptr_wr_data = 32'h0001_0004;
    @(negedge clk);
    ptr_wr_en = 1'b0;
    check(sp == 32'h0001_0004, "R10 pointer load", sp, 32'h0001_0004);

    // Vector table: R1 R2 R3 R4 R6 R8 across all four attribute combinations
    for (int i = 0; i < NV; i++) begin
      lat = i % 3;
      issue(VECS[i].pop, VECS[i].wop, VECS[i].wsp, VECS[i].data);
      wait_done();
      check(done == 1'b1, "R8 done seen", {31'd0, done}, 32'd1);
      check(sp == VECS[i].exp_sp, VECS[i].pop ? "R2 R4 pop pointer" : "R1 R4 push pointer",
            sp, VECS[i].exp_sp);
      check(last_addr == VECS[i].exp_addr, "R1 R2 R4 access address", last_addr, VECS[i].exp_addr);
      check(last_be == VECS[i].exp_be, "R3 byte enables", {28'd0, last_be}, {28'd0, VECS[i].exp_be});
      check(last_we == !VECS[i].pop, "R1 R2 direction", {31'd0, last_we}, {31'd0, !VECS[i].pop});
      check(pop_data == VECS[i].exp_pop, "R6 pop data", pop_data, VECS[i].exp_pop);
      @(negedge clk);
      check(done == 1'b0, "R8 done one cycle", {31'd0, done}, 32'd0);
    end

    // R5: little-endian byte placement of the last doubleword push at 0x10000
    check(mem[32'h0001_0000] == 8'hEF, "R5 lowest byte", {24'd0, mem[32'h0001_0000]}, 32'hEF);
    check(mem[32'h0001_0003] == 8'hDE, "R5 highest byte", {24'd0, mem[32'h0001_0003]}, 32'hDE);
    // R5: narrow push left neighbouring bytes untouched (0xFFFE/0xFFFF written, 0x10000 not)
    check(mem[32'h0000_FFFF] == 8'h99, "R5 narrow push lane 1", {24'd0, mem[32'h0000_FFFF]}, 32'h99);

    // R9: requests and pointer loads ignored while busy
    lat = 4;
    req_count = 0;
    issue(1'b0, 1'b1, 1'b1, 32'hCAFEF00D);
    req_valid = 1'b1; req_pop = 1'b1; ptr_wr_en = 1'b1; ptr_wr_data = 32'h1234_5678;
    wait_done();
    req_valid = 1'b0; ptr_wr_en = 1'b0;
    check(sp == 32'h0000_FFFE, "R9 pointer after busy-time stimulus", sp, 32'h0000_FFFE);
    repeat (4) @(negedge clk);
    check(req_count == 1, "R9 no extra memory request", 32'(req_count), 32'd1);
    check(sp == 32'h0000_FFFE, "R9 pointer load ignored", sp, 32'h0000_FFFE);

    // R10: load wins over a request in the same idle cycle
    lat = 0;
    req_count = 0;
    @(negedge clk);
    req_valid = 1'b1; req_pop = 1'b1; ptr_wr_en = 1'b1; ptr_wr_data = 32'h0000_0100;
    @(negedge clk);
    req_valid = 1'b0; ptr_wr_en = 1'b0;
    check(sp == 32'h0000_0100, "R10 load with request", sp, 32'h0000_0100);
    repeat (3) @(negedge clk);
    check(req_count == 0 && !mem_req, "R10 request dropped", 32'(req_count), 32'd0);

    // R7: request held across a long acknowledge latency
    lat = 6;
    issue(1'b0, 1'b0, 1'b0, 32'h0000_ABCD);
    repeat (3) @(negedge clk);
    check(mem_req == 1'b1 && mem_addr == 32'h0000_00FE, "R7 request held", mem_addr, 32'h0000_00FE);
    wait_done();
    check(sp == 32'h0000_00FE, "R7 R1 pointer after slow ack", sp, 32'h0000_00FE);

    finish_run();
  end

endmodule